// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block sits on the host side of an SMBus segment and handles the one transfer in which the host is the addressed target. In that transfer a device briefly takes the master role to tell the host that it needs attention. The block takes byte-level events from an I2C target front end: start, stop, and each received byte. It returns an acknowledge decision for each byte. Bit timing, line sampling, the alert line and address resolution are handled elsewhere.

The frame has the same shape as a write-word transfer, but the byte that would normally hold the command code carries the sender's own address. The host's address byte with the write direction comes first. The sender address follows, then the low status byte, then the high status byte, and then stop. The sender address and the 16-bit status are latched only when stop follows exactly those three payload bytes. An interrupt is then raised and held until software clears it. If a second good notification completes while the interrupt is still pending, an overrun flag is set and the first notification's values are kept.

Top module: `hn_notify_rx`

## Requirements
- R1: After reset, irq_o and overrun_o are 0, and dev_addr_o and status_o are all zeros.
- R2: An address byte that follows a start is acknowledged only if bits 7:1 equal HOST_ADDR and bit 0, the direction bit, is 0 (write). No other address byte is acknowledged.
- R3: After a matched address, the first three payload bytes are acknowledged. Any payload byte after the third is not acknowledged.
- R4: When stop follows exactly three payload bytes of a matched frame, irq_o is 1 after the clock edge that samples stop_i. At the same point dev_addr_o holds bits 7:1 of the first payload byte and status_o holds {third byte, second byte}.
- R5: A frame whose address bits match HOST_ADDR but whose direction bit is 1 (read) raises no interrupt and leaves dev_addr_o and status_o unchanged.
- R6: A matched write frame that ends with 0, 1, 2, or 4 or more payload bytes raises no interrupt and leaves the latched values unchanged.
- R7: irq_o stays at 1 until clr_i is sampled high. That edge clears both irq_o and overrun_o.
- R8: A good frame that completes while irq_o is 1 and clr_i is 0 sets overrun_o and leaves dev_addr_o and status_o unchanged.
- R9: A repeated start in the middle of a frame discards the partial frame. A complete frame after the repeated start is accepted.
- R10: A good frame that completes in the same cycle as clr_i is treated as a fresh notification: irq_o stays 1, the new values are latched, and overrun_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start seen (one-cycle pulse) |
| stop_i | input | 1 | Stop seen (one-cycle pulse) |
| byte_vld_i | input | 1 | A received byte is present on byte_i (one-cycle pulse) |
| byte_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge decision for the byte on byte_i; combinational while byte_vld_i is high |
| clr_i | input | 1 | Software clear of the interrupt and the overrun flag |
| irq_o | output | 1 | Notification pending |
| overrun_o | output | 1 | A notification was dropped while one was pending |
| dev_addr_o | output | 7 | Latched 7-bit address of the notifying device |
| status_o | output | 16 | Latched status word {high, low} |

## Verification
ack_o is combinational, so the bench reads it 1 ns after it drives byte_vld_i, within the same cycle as the byte. irq_o, overrun_o, dev_addr_o and status_o change at the one clock edge that samples stop_i or clr_i. The bench therefore reads them on the falling edge that follows the end of that pulse. The bench sweeps all 256 address bytes and every payload count from 0 to 5, and runs a set of computed payloads. After each stimulus it checks the outputs at exactly those sample points.

// File: rtl/hn_pkg.sv
package hn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_PAY  = 2'd2,
    ST_SKIP = 2'd3
  } hn_state_e;
endpackage

// File: rtl/hn_frame_fsm.sv
module hn_frame_fsm import hn_pkg::*; #(
  parameter logic [6:0] HOST_ADDR  = 7'h08,
  parameter int         WORD_BYTES = 2,
  localparam int        PAY_BYTES  = 1 + WORD_BYTES,
  localparam int        PW         = 8 * PAY_BYTES,
  localparam int        CW         = $clog2(PAY_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  output logic          ack_o,
  output logic          done_o,
  output logic [PW-1:0] frame_o
);
  hn_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] sh_q;
  logic          addr_hit;
  logic          room;

  assign addr_hit = (byte_i[7:1] == HOST_ADDR) && !byte_i[0];
  assign room     = cnt_q < CW'(PAY_BYTES);

  always_comb begin
    ack_o = 1'b0;
    if (byte_vld_i) begin
      unique case (state_q)
        ST_ADDR: ack_o = addr_hit;
        ST_PAY:  ack_o = room;
        default: ack_o = 1'b0;
      endcase
    end
  end

  assign done_o  = stop_i && (state_q == ST_PAY) && (cnt_q == CW'(PAY_BYTES));
  assign frame_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else if (byte_vld_i) begin
      unique case (state_q)
        ST_ADDR: state_q <= addr_hit ? ST_PAY : ST_SKIP;
        ST_PAY: begin
          if (room) begin
            // first byte ends at the bottom after PAY_BYTES shifts
            sh_q  <= {byte_i, sh_q[PW-1:8]};
            cnt_q <= cnt_q + 1'b1;
          end else begin
            state_q <= ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAY) |-> (cnt_q <= CW'(PAY_BYTES)));
  a_r2_ack_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> byte_vld_i);
  a_r9_start_resets_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0) && (state_q == ST_ADDR));
endmodule

// File: rtl/hn_notify_latch.sv
module hn_notify_latch #(
  parameter int  WORD_BYTES = 2,
  localparam int PW         = 8 * (1 + WORD_BYTES),
  localparam int SW         = 8 * WORD_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [PW-1:0] frame_i,
  input  logic          clr_i,
  output logic          irq_o,
  output logic          overrun_o,
  output logic [6:0]    dev_addr_o,
  output logic [SW-1:0] status_o
);
  logic busy;
  assign busy = irq_o && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      overrun_o  <= 1'b0;
      dev_addr_o <= '0;
      status_o   <= '0;
    end else begin
      if (clr_i) begin
        irq_o     <= 1'b0;
        overrun_o <= 1'b0;
      end
      if (done_i) begin
        if (busy) begin
          overrun_o <= 1'b1;
        end else begin
          irq_o      <= 1'b1;
          dev_addr_o <= frame_i[7:1];
          status_o   <= frame_i[PW-1:8];
        end
      end
    end
  end

  a_r7_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  a_r8_hold_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> ($stable(dev_addr_o) && $stable(status_o)));
  a_r7_clear_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !overrun_o);
endmodule

// File: rtl/hn_notify_rx.sv
module hn_notify_rx #(
  parameter logic [6:0] HOST_ADDR  = 7'h08,
  parameter int         WORD_BYTES = 2,
  localparam int        PW         = 8 * (1 + WORD_BYTES),
  localparam int        SW         = 8 * WORD_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  output logic          ack_o,
  input  logic          clr_i,
  output logic          irq_o,
  output logic          overrun_o,
  output logic [6:0]    dev_addr_o,
  output logic [SW-1:0] status_o
);
  logic          done;
  logic [PW-1:0] frame;

  hn_frame_fsm #(.HOST_ADDR(HOST_ADDR), .WORD_BYTES(WORD_BYTES)) u_fsm (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_vld_i, .byte_i,
    .ack_o, .done_o(done), .frame_o(frame)
  );

  hn_notify_latch #(.WORD_BYTES(WORD_BYTES)) u_latch (
    .clk_i, .rst_ni, .done_i(done), .frame_i(frame), .clr_i,
    .irq_o, .overrun_o, .dev_addr_o, .status_o
  );

  a_r4_irq_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(stop_i));
  a_r8_ovr_needs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(irq_o));
endmodule

// File: tb/sim_hn_notify_rx.sv
module sim_hn_notify_rx;
  localparam int         CLK_P = 10;
  localparam logic [6:0] HOST  = 7'h08;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, byte_vld_i = 0, clr_i = 0;
  logic [7:0] byte_i = '0;
  logic ack_o, irq_o, overrun_o;
  logic [6:0] dev_addr_o;
  logic [15:0] status_o;
  int checks = 0, fails = 0, cyc = 0;
  logic [6:0] exp_dev;
  logic [15:0] exp_st;

  always #(CLK_P/2) clk = ~clk;

  hn_notify_rx #(.HOST_ADDR(HOST), .WORD_BYTES(2)) u0 (.clk_i(clk), .*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic do_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic do_stop(input bit with_clr);
    stop_i = 1; clr_i = with_clr; @(negedge clk); stop_i = 0; clr_i = 0;
  endtask

  task automatic do_clr();
    clr_i = 1; @(negedge clk); clr_i = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
    byte_i = b; byte_vld_i = 1; #1;
    chk(ack_o == exp_ack, req, ack_o, exp_ack);
    @(negedge clk); byte_vld_i = 0;
  endtask

  task automatic frame(input logic [7:0] ab, input int n, input logic [7:0] d0,
                       input logic [7:0] d1, input logic [7:0] d2, input bit with_clr);
    bit hit;
    logic [7:0] d;
    hit = (ab[7:1] == HOST) && !ab[0];
    do_start();
    send(ab, hit, "R2");
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : (k == 1) ? d1 : (k == 2) ? d2 : 8'(k * 29);
      send(d, hit && (k < 3), "R3");
    end
    do_stop(with_clr);
  endtask

  task automatic expect_out(input bit irq, input bit ovr, input string req);
    chk(irq_o == irq, req, irq_o, irq);
    chk(overrun_o == ovr, req, overrun_o, ovr);
    chk(dev_addr_o == exp_dev, req, dev_addr_o, exp_dev);
    chk(status_o == exp_st, req, status_o, exp_st);
  endtask

  initial begin
    exp_dev = '0; exp_st = '0;
    repeat (3) @(negedge clk);
    expect_out(0, 0, "R1");
    rst_ni = 1;
    @(negedge clk);
    expect_out(0, 0, "R1");

    // R2: every address byte, no payload; R6 covers the matched zero-byte case
    for (int a = 0; a < 256; a++) begin
      frame(8'(a), 0, 0, 0, 0, 0);
      expect_out(0, 0, "R2");
    end

    // R3 / R6: payload counts 0..5, only 3 notifies
    for (int n = 0; n < 6; n++) begin
      frame({HOST, 1'b0}, n, 8'(n*17+6), 8'(n*3+1), 8'(n*5+2), 0);
      if (n == 3) begin
        exp_dev = 7'((n*17+6) >> 1); exp_st = {8'(n*5+2), 8'(n*3+1)};
        expect_out(1, 0, "R4");
        do_clr();
        expect_out(0, 0, "R7");
      end else begin
        expect_out(0, 0, "R6");
      end
    end

    // R4: computed payloads; bit 0 of the sender byte must be dropped
    for (int i = 0; i < 16; i++) begin
      logic [7:0] s, lo, hi;
      s = 8'(i*23+1); lo = 8'(i*37+5); hi = 8'(i*91+11);
      frame({HOST, 1'b0}, 3, s, lo, hi, 0);
      exp_dev = s[7:1]; exp_st = {hi, lo};
      expect_out(1, 0, "R4");
      repeat (2) @(negedge clk);
      expect_out(1, 0, "R7");
      do_clr();
      expect_out(0, 0, "R7");
    end

    // R5: read direction on own address
    frame({HOST, 1'b1}, 3, 8'h44, 8'h55, 8'h66, 0);
    expect_out(0, 0, "R5");

    // R8: overrun keeps first values
    frame({HOST, 1'b0}, 3, 8'h20, 8'hA1, 8'hB2, 0);
    exp_dev = 7'h10; exp_st = 16'hB2A1;
    expect_out(1, 0, "R4");
    frame({HOST, 1'b0}, 3, 8'h30, 8'hC3, 8'hD4, 0);
    expect_out(1, 1, "R8");
    do_clr();
    expect_out(0, 0, "R7");

    // R9: repeated start mid-frame, then a complete frame
    do_start();
    send({HOST, 1'b0}, 1, "R9");
    send(8'h5A, 1, "R9");
    send(8'h01, 1, "R9");
    frame({HOST, 1'b0}, 3, 8'h7E, 8'h12, 8'h34, 0);
    exp_dev = 7'h3F; exp_st = 16'h3412;
    expect_out(1, 0, "R9");

    // R10: completion coincident with clear
    frame({HOST, 1'b0}, 3, 8'h62, 8'h9A, 8'hBC, 1);
    exp_dev = 7'h31; exp_st = 16'hBC9A;
    expect_out(1, 0, "R10");
    do_clr();
    expect_out(0, 0, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule